// File: doc/BRIEF.md
# Byte-Wide Memory Device Emulator

This block stands in for a byte-wide memory chip on a board-level model. Its pins behave like those of a common memory part: a set of active-low selects, an active-low output enable and an active-low write enable. An elaboration-time strap chooses between read/write storage and read-only storage. In read-only mode, the write-enable pin is treated as a programming-voltage pin. That pin must sit high before the part returns data.

The data bus is split into an input word, an output word and an output-valid flag. An enclosing pad or bus model uses the flag to decide when the output word is driven and when the bus floats. Every read is registered, so data appears one clock after a valid read combination is presented. When output enable and write enable are both low on a selected part, nothing is stored and nothing is driven. That condition sets a sticky error flag instead.

Top module: `bytemem_emu`

## Requirements
- R1: The device holds 2^ADDR_W independent words, addressed by `addr`. With the default ADDR_W of 10, address 0 and address 1023 both store and return their own values.
- R2: The device is selected only when every bit of `sel_n` is 0. With any bit at 1, no read drives the bus and no write changes storage.
- R3: A read is presented when the device is selected, `oe_n` is 0 and `we_n` is 1. One clock later, `dout_en` is 1 and `dout` holds the word at `addr`.
- R4: With `oe_n` and `we_n` both at 1, `dout_en` is 0 after the next clock and storage is unchanged, whatever `din` carries.
- R5: In read/write mode, a selected device with `we_n` at 0 and `oe_n` at 1 stores `din` at `addr` on the clock edge. `dout_en` is 0 after that edge.
- R6: A selected device with `oe_n` and `we_n` both at 0 stores nothing and has `dout_en` at 0 after the edge. `err` rises to 1 after that edge and stays at 1 until reset. The same pin levels on a deselected device leave `err` at 0.
- R7: In read-only mode, the word at address a is the low 8 bits of 37*a + 90. Write attempts do not change it.
- R8: In read-only mode, a read returns data only while `we_n` (the programming-voltage pin) is 1. With it at 0, `dout_en` is 0 after the edge.
- R9: While `rst_n` is 0, `dout_en` and `err` are 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | NUM_SEL | Active-low selects; all must be low |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable; programming-voltage pin in read-only mode |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Registered read data |
| dout_en | output | 1 | Bus is driven with `dout` when 1 |
| err | output | 1 | Sticky flag for simultaneous output and write enable |

## Verification
The assertions take the control pins as already settled at each rising edge and sampled once per clock. They make no claim about what happens between edges. The bench honours this by changing every input only on the falling edge and reading outputs on the following falling edge. Read checks are also issued only to addresses written earlier in the run, so read/write storage is never read while it still holds unknown contents.

// File: rtl/bytemem_emu.sv
module bytemem_emu #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int NUM_SEL  = 2,
  parameter bit WRITABLE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SEL-1:0] sel_n,
  input  logic               oe_n,
  input  logic               we_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  din,
  output logic [DATA_W-1:0]  dout,
  output logic               dout_en,
  output logic               err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 8;

  logic              picked, rd_req, wr_req, clash;
  logic [DATA_W-1:0] word;

  assign picked = ~|sel_n;
  assign rd_req = picked & ~oe_n & we_n;
  assign wr_req = picked & oe_n & ~we_n;
  assign clash  = picked & ~oe_n & ~we_n;

  generate
    if (WRITABLE) begin : g_ram
      logic [DATA_W-1:0] cells [DEPTH];
      always_ff @(posedge clk)
        if (wr_req) cells[addr] <= din;
      assign word = cells[addr];
    end else begin : g_rom
      logic [PW-1:0] prod;
      assign prod = ({8'd0, addr} * PW'(37)) + PW'(90);
      assign word = prod[DATA_W-1:0];

      assert_rom_vpp_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> !dout_en);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_en <= 1'b0;
      dout    <= '0;
      err     <= 1'b0;
    end else begin
      dout_en <= rd_req;
      if (rd_req) dout <= word;
      if (clash)  err  <= 1'b1;
    end
  end

  assert_no_drive_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel_n) |=> !dout_en);
  assert_idle_floats_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && we_n) |=> !dout_en);
  assert_conflict_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|sel_n) && !oe_n && !we_n) |=> (!dout_en && err));
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|sel_n) && !oe_n && we_n) |=> dout_en);
  assert_reset_clears_R9: assert property (@(posedge clk)
    !rst_n |=> (!dout_en && !err));
endmodule

// File: tb/bytemem_emu_test.sv
module bytemem_emu_test;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] sel_n = '1, rsel_n = '1;
  logic oe_n = 1'b1, we_n = 1'b1, roe_n = 1'b1, rwe_n = 1'b1;
  logic [AW-1:0] addr = '0, raddr = '0;
  logic [DW-1:0] din = '0, rdin = '0;
  logic [DW-1:0] dout, rdout;
  logic dout_en, err, rdout_en, rerr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bytemem_emu #(.ADDR_W(AW), .DATA_W(DW), .NUM_SEL(NS), .WRITABLE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .err(err));

  bytemem_emu #(.ADDR_W(AW), .DATA_W(DW), .NUM_SEL(NS), .WRITABLE(1'b0)) uut_rom (
    .clk(clk), .rst_n(rst_n), .sel_n(rsel_n), .oe_n(roe_n), .we_n(rwe_n),
    .addr(raddr), .din(rdin), .dout(rdout), .dout_en(rdout_en), .err(rerr));

  function automatic logic [DW-1:0] rom_exp(int a);
    int v;
    v = a * 37 + 90;
    return DW'(v & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_n = '1; oe_n = 1'b1; we_n = 1'b1;
    rsel_n = '1; roe_n = 1'b1; rwe_n = 1'b1;
  endtask

  task automatic ram_write(int a, logic [DW-1:0] d);
    @(negedge clk);
    sel_n = '0; oe_n = 1'b1; we_n = 1'b0; addr = AW'(a); din = d;
    @(negedge clk);
    chk("R5 no drive during write", 32'(dout_en), 32'd0);
    idle();
  endtask

  task automatic ram_read(int a, logic [DW-1:0] exp, string req);
    @(negedge clk);
    sel_n = '0; oe_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; addr = AW'(a);
    @(negedge clk);
    chk({req, " dout_en"}, 32'(dout_en), 32'd1);
    chk({req, " dout"}, 32'(dout), 32'(exp));
    idle();
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R9 ram dout_en", 32'(dout_en), 32'd0);
    chk("R9 ram err", 32'(err), 32'd0);
    chk("R9 rom dout_en", 32'(rdout_en), 32'd0);
    chk("R9 rom err", 32'(rerr), 32'd0);
  endtask

  task automatic test_rw();
    ram_write(0, 8'hA5);
    ram_write((1 << AW) - 1, 8'h3C);
    ram_write(517, 8'h81);
    ram_read(0, 8'hA5, "R1 low addr");
    ram_read((1 << AW) - 1, 8'h3C, "R1 high addr");
    ram_read(517, 8'h81, "R3 mid addr");
    ram_write(517, 8'h18);
    ram_read(517, 8'h18, "R5 overwrite");
  endtask

  task automatic test_idle();
    @(negedge clk);
    idle(); addr = AW'(0); din = 8'hFF;
    @(negedge clk);
    chk("R4 idle float", 32'(dout_en), 32'd0);
    ram_read(0, 8'hA5, "R4 storage kept");
  endtask

  task automatic test_select();
    for (int i = 0; i < NS; i++) begin
      @(negedge clk);
      sel_n = '0; sel_n[i] = 1'b1; oe_n = 1'b0; we_n = 1'b1; addr = AW'(0);
      @(negedge clk);
      chk("R2 partial select read", 32'(dout_en), 32'd0);
      sel_n = '0; sel_n[i] = 1'b1; oe_n = 1'b1; we_n = 1'b0; din = 8'h77;
      @(negedge clk);
      idle();
      ram_read(0, 8'hA5, "R2 partial select write");
    end
    @(negedge clk);
    sel_n = '1; sel_n[0] = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    chk("R6 deselected clash no err", 32'(err), 32'd0);
    idle();
  endtask

  task automatic test_conflict();
    @(negedge clk);
    sel_n = '0; oe_n = 1'b0; we_n = 1'b0; addr = AW'(517); din = 8'hEE;
    @(negedge clk);
    chk("R6 clash no drive", 32'(dout_en), 32'd0);
    chk("R6 clash err set", 32'(err), 32'd1);
    idle();
    ram_read(517, 8'h18, "R6 clash no write");
    chk("R6 err sticky", 32'(err), 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R9 reset clears err", 32'(err), 32'd0);
  endtask

  task automatic rom_read(int a, string req);
    @(negedge clk);
    rsel_n = '0; roe_n = 1'b0; rwe_n = 1'b1; raddr = AW'(a);
    @(negedge clk);
    chk({req, " dout_en"}, 32'(rdout_en), 32'd1);
    chk({req, " dout"}, 32'(rdout), 32'(rom_exp(a)));
    idle();
  endtask

  task automatic test_rom();
    rom_read(0, "R7 addr 0");
    rom_read(1, "R7 addr 1");
    rom_read((1 << AW) - 1, "R7 top addr");
    @(negedge clk);
    rsel_n = '0; roe_n = 1'b1; rwe_n = 1'b0; raddr = AW'(1); rdin = 8'h00;
    @(negedge clk);
    idle();
    rom_read(1, "R7 write ignored");
    @(negedge clk);
    rsel_n = '0; roe_n = 1'b0; rwe_n = 1'b0; raddr = AW'(2);
    @(negedge clk);
    chk("R8 vpp low no drive", 32'(rdout_en), 32'd0);
    idle();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_rw();
    test_idle();
    test_select();
    test_conflict();
    test_rom();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule